// File: doc/BRIEF.md
# UART Receiver With Error Flags

This block turns an asynchronous serial line into parallel characters. The line is first passed through a two-stage synchronizer. It is then sampled at sixteen times the bit rate, and that rate comes from a programmable divisor of the system clock. Each character is rebuilt least significant bit first and placed in a single holding register. A one-cycle strobe marks its arrival, and a data-ready flag stays up until the consumer pulses a read strobe.

Four sticky status flags record line faults:
- **Framing:** the stop bit is low.
- **Parity:** optional even or odd parity does not match.
- **Break:** the whole character time is low.
- **Overrun:** a new character lands while the previous one is still unread.

A separate clear strobe drops all four error flags. A start bit that has gone high again by its midpoint is discarded as a glitch. After any low stop sample, the receiver waits for the line to go high before it looks for a new start bit.

Top module: `uart_rx_flags`

## Requirements
- R1: A frame is one low start bit, DATA_BITS data bits least significant first, an optional parity bit and one high stop bit. On the stop sample the data bits are copied to `rxData`, `rxValid` is set and `rxStrobe` is high for exactly one cycle.
- R2: One bit lasts 16*(`cfgDiv`+1) clock cycles. The start bit is sampled at its midpoint (8 oversample ticks after the falling edge is seen), and every later bit is sampled 16 ticks after the previous sample.
- R3: If the line is high at the start-bit midpoint, the start is dropped and no character, strobe or flag results.
- R4: A low stop sample sets `frameErr`, and the character is still delivered to `rxData`.
- R5: With `cfgParEn`=1, one parity bit follows the data. With `cfgParOdd`=0 (even), the data ones plus the parity bit must be an even count. With `cfgParOdd`=1 (odd), that count must be odd. A mismatch sets `parErr`.
- R6: With `cfgParEn`=0, no parity bit is expected, the stop bit directly follows the data, and `parErr` is never set.
- R7: When every data sample, the parity sample (if enabled) and the stop sample are all low, `breakErr` and `frameErr` are both set, and 0x00 is delivered.
- R8: After a low stop sample, no new start is accepted until the line has been seen high. A line held low for many character times yields one character only.
- R9: `overrunErr` is set when a character completes while `rxValid` is 1 and `rdStrobe` is not high in that cycle. The new character replaces the old one in `rxData`.
- R10: A `rdStrobe` pulse clears `rxValid` and leaves `rxData` unchanged. An `errClr` pulse clears all four error flags and leaves `rxValid` unchanged.
- R11: After reset, `rxValid`, `rxStrobe`, all error flags and `rxData` are 0.
- R12: The error flags are sticky: a later fault-free character does not clear them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxIn | input | 1 | Serial line, idle high |
| cfgDiv | input | DIV_W | Divisor; oversample tick every cfgDiv+1 clocks |
| cfgParEn | input | 1 | 1 = a parity bit follows the data |
| cfgParOdd | input | 1 | 0 = even parity, 1 = odd parity |
| rdStrobe | input | 1 | Read pulse, clears the data-ready flag |
| errClr | input | 1 | Pulse that clears the error flags |
| rxData | output | DATA_BITS | Holding register |
| rxValid | output | 1 | Data-ready flag |
| rxStrobe | output | 1 | One-cycle pulse per received character |
| frameErr | output | 1 | Sticky framing error |
| parErr | output | 1 | Sticky parity error |
| breakErr | output | 1 | Sticky break detected |
| overrunErr | output | 1 | Sticky overrun |

## Verification
The bench builds the block with its default parameters: eight data bits, 16x oversampling and a 16-bit divisor. The divisor is a port, and the bench sweeps it across 0, 1 and 3, so one bit lasts 16, 32 or 64 clocks. These short frames let many characters, a twelve-bit-long break and a back-to-back overrun fit in a short run. The sweep also shows that mid-bit sampling tracks the divisor.

// File: rtl/srx_pkg.sv
package srx_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic baudSync;  // restart the baud divider on a detected falling edge
    logic shiftEn;   // capture one data bit
    logic parCap;    // capture the parity bit
    logic loadChar;  // stop sample: move character to holding register
  } srxStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_WAITHI
  } srxState_t;
endpackage

// File: rtl/srx_ctrl.sv
module srx_ctrl
  import srx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int OVS       = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       rxS,
  input  logic       parEn,
  output srxStrobe_t strb
);
  localparam int OVS_W = $clog2(OVS);
  localparam int BIT_W = $clog2(DATA_BITS + 1);

  srxState_t state, stateNxt;
  logic [OVS_W-1:0] ovsCnt;
  logic [BIT_W-1:0] bitCnt;
  logic midStart, bitEnd;

  assign midStart = tick && (ovsCnt == OVS_W'(OVS / 2 - 1));
  assign bitEnd   = tick && (ovsCnt == OVS_W'(OVS - 1));

  always_comb begin
    stateNxt = state;
    strb     = '0;
    case (state)
      ST_IDLE: if (!rxS) begin
        strb.baudSync = 1'b1;
        stateNxt      = ST_START;
      end
      ST_START: if (midStart) stateNxt = rxS ? ST_IDLE : ST_DATA;
      ST_DATA: if (bitEnd) begin
        strb.shiftEn = 1'b1;
        if (bitCnt == BIT_W'(DATA_BITS - 1)) stateNxt = parEn ? ST_PAR : ST_STOP;
      end
      ST_PAR: if (bitEnd) begin
        strb.parCap = 1'b1;
        stateNxt    = ST_STOP;
      end
      ST_STOP: if (bitEnd) begin
        strb.loadChar = 1'b1;
        stateNxt      = rxS ? ST_IDLE : ST_WAITHI;
      end
      ST_WAITHI: if (rxS) stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      ovsCnt <= '0;
      bitCnt <= '0;
    end else begin
      state <= stateNxt;
      if (stateNxt != state || bitEnd) ovsCnt <= '0;
      else if (tick)                    ovsCnt <= ovsCnt + 1'b1;
      if (state != ST_DATA) bitCnt <= '0;
      else if (bitEnd)      bitCnt <= bitCnt + 1'b1;
    end
  end

  // R2: bit captures happen only on oversample ticks
  p_strobe_on_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.shiftEn || strb.parCap || strb.loadChar) |-> tick);

  // R8: a low line keeps the receiver parked after a bad stop bit
  p_wait_high_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAITHI && !rxS) |=> (state == ST_WAITHI));
endmodule

// File: rtl/srx_dpath.sv
module srx_dpath
  import srx_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxIn,
  input  logic [DIV_W-1:0]     cfgDiv,
  input  logic                 cfgParEn,
  input  logic                 cfgParOdd,
  input  logic                 rdStrobe,
  input  logic                 errClr,
  input  srxStrobe_t           strb,
  output logic                 tick,
  output logic                 rxS,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxValid,
  output logic                 rxStrobe,
  output logic                 frameErr,
  output logic                 parErr,
  output logic                 breakErr,
  output logic                 overrunErr
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic [DIV_W-1:0]       divCnt;
  logic [DATA_BITS-1:0]   shiftQ;
  logic                   parQ;
  logic                   parBad, stopLow, allLow, ovrHit;

  assign rxS  = syncQ[SYNC_STAGES-1];
  assign tick = (divCnt == cfgDiv);

  assign parBad  = cfgParEn && ((^shiftQ) ^ parQ ^ cfgParOdd);
  assign stopLow = !rxS;
  assign allLow  = stopLow && (shiftQ == '0) && !(cfgParEn && parQ);
  assign ovrHit  = strb.loadChar && rxValid && !rdStrobe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ  <= '1;
      divCnt <= '0;
      shiftQ <= '0;
      parQ   <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], rxIn};
      if (strb.baudSync || tick) divCnt <= '0;
      else                       divCnt <= divCnt + 1'b1;
      if (strb.shiftEn) shiftQ <= {rxS, shiftQ[DATA_BITS-1:1]};
      if (strb.parCap)  parQ   <= rxS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData     <= '0;
      rxValid    <= 1'b0;
      rxStrobe   <= 1'b0;
      frameErr   <= 1'b0;
      parErr     <= 1'b0;
      breakErr   <= 1'b0;
      overrunErr <= 1'b0;
    end else begin
      rxStrobe <= strb.loadChar;
      if (strb.loadChar) rxData <= shiftQ;
      if (strb.loadChar)  rxValid <= 1'b1;
      else if (rdStrobe)  rxValid <= 1'b0;
      if (errClr) begin
        frameErr   <= 1'b0;
        parErr     <= 1'b0;
        breakErr   <= 1'b0;
        overrunErr <= 1'b0;
      end
      if (strb.loadChar) begin
        if (stopLow) frameErr   <= 1'b1;
        if (parBad)  parErr     <= 1'b1;
        if (allLow)  breakErr   <= 1'b1;
        if (ovrHit)  overrunErr <= 1'b1;
      end
    end
  end

  p_load_sets_valid_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadChar |=> (rxValid && rxStrobe));

  p_overrun_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadChar && rxValid && !rdStrobe) |=> overrunErr);

  p_read_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !strb.loadChar) |=> !rxValid);

  p_break_frame_r7: assert property (@(posedge clk) disable iff (!rstN)
    breakErr |-> frameErr);

  p_sticky_r12: assert property (@(posedge clk) disable iff (!rstN)
    (frameErr && !errClr) |=> frameErr);
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
  import srx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int OVS       = 16,
  parameter int DIV_W     = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxIn,
  input  logic [DIV_W-1:0]     cfgDiv,
  input  logic                 cfgParEn,
  input  logic                 cfgParOdd,
  input  logic                 rdStrobe,
  input  logic                 errClr,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxValid,
  output logic                 rxStrobe,
  output logic                 frameErr,
  output logic                 parErr,
  output logic                 breakErr,
  output logic                 overrunErr
);
  srxStrobe_t strb;
  logic tick, rxS;

  srx_ctrl #(.DATA_BITS(DATA_BITS), .OVS(OVS)) uCtrl (
    .clk(clk), .rstN(rstN), .tick(tick), .rxS(rxS), .parEn(cfgParEn), .strb(strb)
  );

  srx_dpath #(.DATA_BITS(DATA_BITS), .DIV_W(DIV_W), .SYNC_STAGES(2)) uDpath (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .cfgDiv(cfgDiv),
    .cfgParEn(cfgParEn), .cfgParOdd(cfgParOdd),
    .rdStrobe(rdStrobe), .errClr(errClr), .strb(strb),
    .tick(tick), .rxS(rxS), .rxData(rxData), .rxValid(rxValid),
    .rxStrobe(rxStrobe), .frameErr(frameErr), .parErr(parErr),
    .breakErr(breakErr), .overrunErr(overrunErr)
  );
endmodule

// File: tb/sim_uart_rx_flags.sv
`timescale 1ns/1ps
module sim_uart_rx_flags;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxIn = 1'b1;
  logic [15:0] cfgDiv = 16'd1;
  logic cfgParEn = 1'b0, cfgParOdd = 1'b0;
  logic rdStrobe = 1'b0, errClr = 1'b0;
  logic [7:0] rxData;
  logic rxValid, rxStrobe, frameErr, parErr, breakErr, overrunErr;

  int nChecks = 0, nFails = 0, strobeCnt = 0;

  always #2.5 clk = ~clk;

  uart_rx_flags u0 (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .cfgDiv(cfgDiv),
    .cfgParEn(cfgParEn), .cfgParOdd(cfgParOdd),
    .rdStrobe(rdStrobe), .errClr(errClr),
    .rxData(rxData), .rxValid(rxValid), .rxStrobe(rxStrobe),
    .frameErr(frameErr), .parErr(parErr), .breakErr(breakErr),
    .overrunErr(overrunErr)
  );

  always @(negedge clk) if (rxStrobe) strobeCnt++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic holdBit(input logic v);
    rxIn = v;
    repeat (16 * (int'(cfgDiv) + 1)) @(negedge clk);
  endtask

  task automatic sendChar(input logic [7:0] d, input logic parFlip, input logic stopVal);
    holdBit(1'b0);
    for (int i = 0; i < 8; i++) holdBit(d[i]);
    if (cfgParEn) holdBit((^d) ^ cfgParOdd ^ parFlip);
    holdBit(stopVal);
    holdBit(1'b1);
    holdBit(1'b1);
  endtask

  task automatic pulseRead();
    @(negedge clk) rdStrobe = 1'b1;
    @(negedge clk) rdStrobe = 1'b0;
  endtask

  task automatic pulseClr();
    @(negedge clk) errClr = 1'b1;
    @(negedge clk) errClr = 1'b0;
  endtask

  task automatic tReset();
    chk("R11 rxValid", rxValid, 0);
    chk("R11 rxStrobe", rxStrobe, 0);
    chk("R11 rxData", rxData, 0);
    chk("R11 flags", {frameErr, parErr, breakErr, overrunErr}, 0);
  endtask

  task automatic tBasic();
    int c0 = strobeCnt;
    cfgDiv = 16'd1; cfgParEn = 1'b0;
    sendChar(8'hA5, 1'b0, 1'b1);
    chk("R1 data", rxData, 8'hA5);
    chk("R1 valid", rxValid, 1);
    chk("R1 one strobe", strobeCnt - c0, 1);
    chk("R6 no parity err", parErr, 0);
    pulseRead();
    chk("R10 read clears valid", rxValid, 0);
    chk("R10 data kept", rxData, 8'hA5);
  endtask

  task automatic tDivisor();
    cfgDiv = 16'd0;
    sendChar(8'h3C, 1'b0, 1'b1);
    chk("R2 div0 data", rxData, 8'h3C);
    pulseRead();
    cfgDiv = 16'd3;
    sendChar(8'hC3, 1'b0, 1'b1);
    chk("R2 div3 data", rxData, 8'hC3);
    chk("R2 div3 clean", {frameErr, parErr}, 0);
    pulseRead();
    cfgDiv = 16'd1;
  endtask

  task automatic tGlitch();
    int c0 = strobeCnt;
    rxIn = 1'b0;
    repeat (6) @(negedge clk);
    holdBit(1'b1); holdBit(1'b1); holdBit(1'b1);
    chk("R3 no char", rxValid, 0);
    chk("R3 no strobe", strobeCnt - c0, 0);
    chk("R3 no flags", {frameErr, parErr, breakErr}, 0);
  endtask

  task automatic tParity();
    cfgParEn = 1'b1; cfgParOdd = 1'b0;
    sendChar(8'h07, 1'b0, 1'b1);
    chk("R5 even ok", parErr, 0);
    chk("R5 even data", rxData, 8'h07);
    pulseRead();
    sendChar(8'h07, 1'b1, 1'b1);
    chk("R5 even bad", parErr, 1);
    pulseClr();
    chk("R10 clr parErr", parErr, 0);
    chk("R10 clr keeps valid", rxValid, 1);
    pulseRead();
    cfgParOdd = 1'b1;
    sendChar(8'h81, 1'b0, 1'b1);
    chk("R5 odd ok", parErr, 0);
    pulseRead();
    sendChar(8'h81, 1'b1, 1'b1);
    chk("R5 odd bad", parErr, 1);
    chk("R5 odd data", rxData, 8'h81);
    pulseClr(); pulseRead();
    cfgParEn = 1'b0; cfgParOdd = 1'b0;
  endtask

  task automatic tFrame();
    sendChar(8'h5A, 1'b0, 1'b0);
    chk("R4 frame err", frameErr, 1);
    chk("R4 no break", breakErr, 0);
    chk("R4 data kept", rxData, 8'h5A);
    pulseRead();
    sendChar(8'h11, 1'b0, 1'b1);
    chk("R12 sticky frame", frameErr, 1);
    chk("R12 good data", rxData, 8'h11);
    pulseClr(); pulseRead();
    chk("R10 clr frame", frameErr, 0);
  endtask

  task automatic tBreak();
    int c0 = strobeCnt;
    rxIn = 1'b0;
    repeat (12) holdBit(1'b0);
    holdBit(1'b1); holdBit(1'b1);
    chk("R7 break", breakErr, 1);
    chk("R7 frame with break", frameErr, 1);
    chk("R7 zero data", rxData, 0);
    chk("R8 one char only", strobeCnt - c0, 1);
    pulseClr(); pulseRead();
    sendChar(8'h99, 1'b0, 1'b1);
    chk("R8 rearmed data", rxData, 8'h99);
    chk("R8 rearmed clean", {frameErr, breakErr}, 0);
    pulseRead();
  endtask

  task automatic tOverrun();
    sendChar(8'h12, 1'b0, 1'b1);
    chk("R9 no early overrun", overrunErr, 0);
    sendChar(8'h34, 1'b0, 1'b1);
    chk("R9 overrun", overrunErr, 1);
    chk("R9 newest data", rxData, 8'h34);
    pulseClr();
    chk("R10 clr overrun", overrunErr, 0);
    chk("R10 valid after clr", rxValid, 1);
    pulseRead();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    tReset();
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    tBasic();
    tDivisor();
    tGlitch();
    tParity();
    tFrame();
    tBreak();
    tOverrun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule